// File: doc/BRIEF.md
# PC-relative address generation unit

This unit executes four address-forming operations of a 32-bit RISC-V core subset: the upper-immediate add to the program counter (AUIPC), word load (LW), word store (SW) and register-indirect jump with link (JALR). It owns a 32-entry, 32-bit register file whose entry zero always reads as zero. A decoded operation arrives with its program counter, a 20-bit immediate field, register indices and an operation code. The unit then produces one or more of these: a register write-back, a memory read or write strobe with a word address and store data, and a next-PC value with a redirect flag.

The unit joins two kinds of add. The upper-immediate add puts a 20-bit value into bits 31:12 above the PC. The base-plus-offset add sign-extends a 12-bit offset and adds it to a register. Together they reach any 32-bit address in two operations, and a negative low offset is folded in correctly. Operations enter on a valid/ready handshake. An operation is taken on a clock edge where `op_valid` and `op_ready` are both high. The issuer must hold every `op_*` field stable while `op_valid` is high and `op_ready` is low. `op_ready` drops for exactly one cycle after each accepted load, while the load data returns from the synchronous memory.

Top module: `pcrel_agu`

## Requirements
- R1: `op_kind`=0 (AUIPC) writes `op_pc + (op_imm << 12)` to register `op_rd`, modulo 2^32. The write-back is visible on `wb_*` in the cycle the operation is accepted.
- R2: For `op_kind` 1, 2 and 3, the effective address is the rs1 value plus `op_imm[11:0]` sign-extended to 32 bits, wrapping modulo 2^32. The offset range is -2048 to +2047.
- R3: `op_kind`=1 (LW) raises `mem_rd` with the word address in its accept cycle. In the next cycle `op_ready` is low and `mem_rdata` is written back to `op_rd`.
- R4: `op_kind`=2 (SW) raises `mem_wr` with the word address and the rs2 value as `mem_wdata` in its accept cycle. It performs no register write.
- R5: `op_kind`=3 (JALR) raises `redirect` with `npc` equal to the effective address with bit 0 cleared. It writes `op_pc + 4` to `op_rd`. When rd equals rs1, the target uses the old rs1 value.
- R6: Register x0 always reads as zero. An operation whose rd is x0 produces no write-back (`wb_en` stays low).
- R7: For any operation other than JALR, `npc` equals `op_pc + 4` and `redirect` is low.
- R8: Nothing is accepted while `op_valid` is low: all strobes and `wb_en` stay low. `mem_rd` and `mem_wr` are never high together.
- R9: After reset, `op_ready` is high, all strobes are low and every register reads zero.
- R10: An AUIPC with immediate 1 into a register, followed by an LW with offset -400 from that register, reads the word at PC + 4096 - 400.
- R11: `mem_addr` bits 1:0 are always zero. The low two bits of the effective address are dropped for LW and SW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can take an operation this cycle |
| op_kind | input | 2 | 0 AUIPC, 1 LW, 2 SW, 3 JALR |
| op_pc | input | 32 | Address of this operation |
| op_imm | input | 20 | Upper immediate (AUIPC) or offset in bits 11:0 |
| op_rd | input | 5 | Destination register index |
| op_rs1 | input | 5 | Base register index |
| op_rs2 | input | 5 | Store data register index |
| wb_en | output | 1 | Register write-back this cycle |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 32 | Write-back value |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| npc | output | 32 | Next program counter |
| redirect | output | 1 | Jump taken, `npc` is the target |

## Verification
The hardest case is a jump whose destination is also its base register. The only way to see that the old value was used is through the jump target and a later store of the same register. The stimulus first fills the register with an AUIPC. It then issues the self-linking JALR and stores that register to memory, so both the target and the new link value appear on the ports. Wrap-around is reached in two ways: an all-ones upper immediate, and a negative offset from x0. A store to an unaligned address followed by a load of the same word shows that the low address bits are dropped.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;
  typedef enum logic [1:0] {
    OP_AUIPC = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_JUMPR = 2'd3
  } agu_op_e;
endpackage

// File: rtl/pcrel_regfile.sv
module pcrel_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   ra_idx,
  output logic [XLEN-1:0] ra_data,
  input  logic [IW-1:0]   rb_idx,
  output logic [XLEN-1:0] rb_data,
  input  logic            we,
  input  logic [IW-1:0]   w_idx,
  input  logic [XLEN-1:0] w_data
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n)                               regs[g] <= '0;
        else if (we && (w_idx == IW'(g)))         regs[g] <= w_data;
      end
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];
endmodule

// File: rtl/pcrel_addr_calc.sv
module pcrel_addr_calc
  import pcrel_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int UIMM_W = 20,
  parameter int OFF_W  = 12,
  localparam int SHIFT = XLEN - UIMM_W
) (
  input  agu_op_e           op,
  input  logic [XLEN-1:0]   pc,
  input  logic [UIMM_W-1:0] imm,
  input  logic [XLEN-1:0]   base,
  output logic [XLEN-1:0]   upper_sum,
  output logic [XLEN-1:0]   word_addr,
  output logic [XLEN-1:0]   link,
  output logic [XLEN-1:0]   next_pc
);
  logic [XLEN-1:0] off_ext, eff;

  assign off_ext   = {{(XLEN-OFF_W){imm[OFF_W-1]}}, imm[OFF_W-1:0]};
  assign eff       = base + off_ext;
  assign upper_sum = pc + {imm, {SHIFT{1'b0}}};
  assign word_addr = eff & ~XLEN'(3);
  assign link      = pc + XLEN'(4);
  assign next_pc   = (op == OP_JUMPR) ? (eff & ~XLEN'(1)) : link;
endmodule

// File: rtl/pcrel_lsu_ctrl.sv
module pcrel_lsu_ctrl
  import pcrel_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  agu_op_e       op,
  input  logic [IW-1:0] rd,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          jump,
  output logic          wb_en,
  output logic [IW-1:0] wb_idx,
  output logic          wb_from_mem
);
  logic          wait_q;
  logic [IW-1:0] pend_q;
  logic          fire;

  assign op_ready = !wait_q;
  assign fire     = op_valid && !wait_q;
  assign rd_stb   = fire && (op == OP_LOAD);
  assign wr_stb   = fire && (op == OP_STORE);
  assign jump     = fire && (op == OP_JUMPR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      pend_q <= '0;
    end else begin
      wait_q <= rd_stb;
      if (rd_stb) pend_q <= rd;
    end
  end

  always_comb begin
    wb_from_mem = wait_q;
    if (wait_q) begin
      wb_en  = (pend_q != '0);
      wb_idx = pend_q;
    end else begin
      wb_en  = fire && ((op == OP_AUIPC) || (op == OP_JUMPR)) && (rd != '0);
      wb_idx = rd;
    end
  end

  // R3: a load is always followed by one stall cycle
  a_r3_load_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !op_ready);
  // R3: load data lands in the register named at issue
  a_r3_load_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd != '0) |=> (wb_en && wb_idx == $past(rd)));
  // R8: read and write strobes are exclusive
  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  // R8: no activity without an offered operation outside a load stall
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && op_ready) |-> !(rd_stb || wr_stb || jump || wb_en));
endmodule

// File: rtl/pcrel_agu.sv
module pcrel_agu
  import pcrel_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NREG   = 32,
  parameter int UIMM_W = 20,
  parameter int OFF_W  = 12,
  localparam int IW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_kind,
  input  logic [XLEN-1:0]   op_pc,
  input  logic [UIMM_W-1:0] op_imm,
  input  logic [IW-1:0]     op_rd,
  input  logic [IW-1:0]     op_rs1,
  input  logic [IW-1:0]     op_rs2,
  output logic              wb_en,
  output logic [IW-1:0]     wb_idx,
  output logic [XLEN-1:0]   wb_data,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [XLEN-1:0]   npc,
  output logic              redirect
);
  agu_op_e         op;
  logic [XLEN-1:0] rs1_val, rs2_val, upper_sum, link;
  logic            wb_from_mem;

  assign op = agu_op_e'(op_kind);

  pcrel_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(op_rs1), .ra_data(rs1_val),
    .rb_idx(op_rs2), .rb_data(rs2_val),
    .we(wb_en), .w_idx(wb_idx), .w_data(wb_data)
  );

  pcrel_addr_calc #(.XLEN(XLEN), .UIMM_W(UIMM_W), .OFF_W(OFF_W)) u_calc (
    .op(op), .pc(op_pc), .imm(op_imm), .base(rs1_val),
    .upper_sum(upper_sum), .word_addr(mem_addr), .link(link), .next_pc(npc)
  );

  pcrel_lsu_ctrl #(.IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op(op), .rd(op_rd), .rd_stb(mem_rd), .wr_stb(mem_wr), .jump(redirect),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_from_mem(wb_from_mem)
  );

  assign mem_wdata = rs2_val;

  always_comb begin
    if (wb_from_mem)        wb_data = mem_rdata;
    else if (op == OP_JUMPR) wb_data = link;
    else                    wb_data = upper_sum;
  end

  // R6: register zero never appears as a write-back target
  a_r6_no_x0_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_idx != '0));
  // R11: memory strobes carry word-aligned addresses
  a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00));
  // R5: jump targets are always even
  a_r5_target_even: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (npc[0] == 1'b0));
  // R7: redirect only accompanies a jump operation
  a_r7_redirect_kind: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (op == OP_JUMPR));
endmodule

// File: tb/sim_pcrel_agu.sv
`timescale 1ns/1ps
module sim_pcrel_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_kind = '0;
  logic [31:0] op_pc = '0;
  logic [19:0] op_imm = '0;
  logic [4:0]  op_rd = '0, op_rs1 = '0, op_rs2 = '0;
  logic        wb_en, mem_rd, mem_wr, redirect;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data, mem_addr, mem_wdata, npc;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [31:0] a; logic [31:0] b; int req; } exp_t;
  exp_t wbq[$], ldq[$], stq[$], jq[$];
  exp_t e;

  logic [31:0] mem  [256];
  logic [31:0] mmem [256];
  logic [31:0] mrf  [32];

  always #10 clk = ~clk;

  pcrel_agu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_pc(op_pc), .op_imm(op_imm), .op_rd(op_rd),
    .op_rs1(op_rs1), .op_rs2(op_rs2), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .npc(npc), .redirect(redirect)
  );

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 32'h1357_0000 ^ (i * 32'h0101_0003);
      mmem[i] = 32'h1357_0000 ^ (i * 32'h0101_0003);
    end
    for (int i = 0; i < 32; i++) mrf[i] = '0;
  end

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
  end

  task automatic chk(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual %08h expected %08h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (wb_en) begin
        if (wbq.size() == 0) chk(0, 6, {27'd0, wb_idx}, 32'hFFFF_FFFF);
        else begin
          e = wbq.pop_front();
          chk(wb_idx == e.a[4:0], e.req, {27'd0, wb_idx}, e.a);
          chk(wb_data == e.b, e.req, wb_data, e.b);
        end
      end
      if (mem_rd) begin
        if (ldq.size() == 0) chk(0, 3, mem_addr, 32'hFFFF_FFFF);
        else begin e = ldq.pop_front(); chk(mem_addr == e.a, e.req, mem_addr, e.a); end
      end
      if (mem_wr) begin
        if (stq.size() == 0) chk(0, 4, mem_addr, 32'hFFFF_FFFF);
        else begin
          e = stq.pop_front();
          chk(mem_addr == e.a, e.req, mem_addr, e.a);
          chk(mem_wdata == e.b, e.req, mem_wdata, e.b);
        end
      end
      if (redirect) begin
        if (jq.size() == 0) chk(0, 5, npc, 32'hFFFF_FFFF);
        else begin e = jq.pop_front(); chk(npc == e.a, e.req, npc, e.a); end
      end
    end
  end

  // driver: computes expectations from its own register and memory model
  task automatic do_op(input logic [1:0] k, input logic [31:0] pc, input logic [19:0] imm,
                       input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2,
                       input int req);
    logic [31:0] a, b, ea, res;
    a  = mrf[rs1];
    b  = mrf[rs2];
    ea = a + {{20{imm[11]}}, imm[11:0]};
    case (k)
      2'd0: begin
        res = pc + {imm, 12'h000};
        if (rd != 0) begin wbq.push_back('{{27'd0, rd}, res, req}); mrf[rd] = res; end
      end
      2'd1: begin
        ldq.push_back('{ea & ~32'd3, 32'd0, req});
        res = mmem[ea[9:2]];
        if (rd != 0) begin wbq.push_back('{{27'd0, rd}, res, req}); mrf[rd] = res; end
      end
      2'd2: begin
        stq.push_back('{ea & ~32'd3, b, req});
        mmem[ea[9:2]] = b;
      end
      default: begin
        jq.push_back('{ea & ~32'd1, 32'd0, req});
        if (rd != 0) begin wbq.push_back('{{27'd0, rd}, pc + 32'd4, req}); mrf[rd] = pc + 32'd4; end
      end
    endcase
    op_valid = 1'b1; op_kind = k; op_pc = pc; op_imm = imm;
    op_rd = rd; op_rs1 = rs1; op_rs2 = rs2;
    forever begin
      @(negedge clk);
      if (op_ready) break;
    end
    if (k != 2'd3) begin
      // R7: sequential next PC, no redirect
      chk(npc == pc + 32'd4, 7, npc, pc + 32'd4);
      chk(!redirect, 7, {31'd0, redirect}, 32'd0);
    end
    @(posedge clk); #1;
    op_valid = 1'b0;
    if (k == 2'd1) begin
      @(negedge clk);
      chk(!op_ready, 3, {31'd0, op_ready}, 32'd0);   // R3 stall cycle
      @(posedge clk); #1;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(op_ready, 9, {31'd0, op_ready}, 32'd1);
    chk(!(mem_rd || mem_wr || wb_en || redirect), 9, {28'd0, mem_rd, mem_wr, wb_en, redirect}, 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;
    // R6 and R9: x0 and freshly reset x9 both store zero
    do_op(2'd2, 32'h100, 20'h00040, 5'd0, 5'd0, 5'd0, 6);
    do_op(2'd2, 32'h104, 20'h00044, 5'd0, 5'd0, 5'd9, 9);
    // R1 then R10: AUIPC imm 1 plus LW offset -400 (12'hE70), also R2
    do_op(2'd0, 32'h0000_1000, 20'h00001, 5'd5, 5'd0, 5'd0, 1);
    do_op(2'd1, 32'h0000_1004, 20'h00E70, 5'd6, 5'd5, 5'd0, 10);
    // R1: all-ones upper immediate wraps
    do_op(2'd0, 32'h0000_0010, 20'hFFFFF, 5'd7, 5'd0, 5'd0, 1);
    // R2: extreme offsets +2047 and -2048; R11: unaligned low bits dropped
    do_op(2'd1, 32'h14, 20'h007FF, 5'd10, 5'd7, 5'd0, 2);
    do_op(2'd1, 32'h18, 20'h00800, 5'd11, 5'd7, 5'd0, 2);
    // R4 and R11: unaligned store, read back through a load
    do_op(2'd2, 32'h1C, 20'h00003, 5'd0, 5'd5, 5'd6, 4);
    do_op(2'd1, 32'h20, 20'h00000, 5'd8, 5'd5, 5'd0, 11);
    do_op(2'd2, 32'h24, 20'h00010, 5'd0, 5'd0, 5'd8, 4);
    // R2: negative offset from x0 wraps to the top of memory
    do_op(2'd2, 32'h28, 20'h00FFC, 5'd0, 5'd0, 5'd6, 2);
    // R5: odd target, link written
    do_op(2'd3, 32'h0000_3000, 20'h00005, 5'd1, 5'd5, 5'd0, 5);
    do_op(2'd2, 32'h2C, 20'h00020, 5'd0, 5'd0, 5'd1, 5);
    // R5: rd equals rs1, old base used for the target
    do_op(2'd3, 32'h0000_4000, 20'h00101, 5'd5, 5'd5, 5'd0, 5);
    do_op(2'd2, 32'h30, 20'h00024, 5'd0, 5'd0, 5'd5, 5);
    // R6: write to x0 discarded, x0 still stores zero
    do_op(2'd0, 32'h0000_5000, 20'h12345, 5'd0, 5'd0, 5'd0, 6);
    do_op(2'd3, 32'h0000_5004, 20'h00040, 5'd0, 5'd0, 5'd0, 6);
    do_op(2'd2, 32'h34, 20'h00028, 5'd0, 5'd0, 5'd0, 6);
    // R8: idle with fields set, nothing happens
    op_kind = 2'd1; op_rd = 5'd12; op_rs1 = 5'd5;
    repeat (2) begin
      @(negedge clk);
      chk(!(mem_rd || mem_wr || wb_en || redirect), 8,
          {28'd0, mem_rd, mem_wr, wb_en, redirect}, 32'd0);
    end
    @(posedge clk); #1;
    // R3: load into x0 still stalls, no write-back
    do_op(2'd1, 32'h38, 20'h00000, 5'd0, 5'd5, 5'd0, 3);
    repeat (3) @(posedge clk);
    chk(wbq.size() == 0 && ldq.size() == 0 && stq.size() == 0 && jq.size() == 0, 8,
        wbq.size() + ldq.size() + stq.size() + jq.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule